// File: doc/BRIEF.md
# Transfer Descriptor Retry Counter

This block holds the error-retry and completion state of one USB host transfer descriptor. Software loads a starting 2-bit error budget, a 2-bit PID code, a flag that says whether the endpoint is high-speed, and a flag that says whether the descriptor sits in the asynchronous schedule. After that, the block takes at most one transaction outcome per clock: success, transaction error, data buffer error, babble or stall.

The block keeps the remaining error budget, active and halted flags, a sticky status bit for each error cause, and an error interrupt request gated by an enable input. Transaction errors use up the budget. Babble and stall halt the descriptor at once. Data buffer errors are host-side faults and do not touch the budget. A successful IN or OUT on a high-speed or asynchronous descriptor refills the budget. A starting budget of zero means retries without limit.

The block also turns the PID code into the token byte to send, and it flags a reserved PID code and a risky load.

Top module: `td_retry_ctrl`

## Requirements
- R1: A load sets the count to the loaded value, sets active, and clears halted, all status bits and the interrupt request. A load takes priority over an outcome presented in the same cycle.
- R2: A transaction error (outcome code 1) with a count above one decrements the count by one and leaves the descriptor active.
- R3: A transaction error with a count of one makes the count zero, clears active, sets halted and sets status bit 0 (transaction error).
- R4: With a count of zero, transaction errors and successes leave the count at zero and never halt the descriptor.
- R5: A data buffer error (outcome code 2) leaves the count unchanged, sets status bit 1, and does not halt.
- R6: Babble (code 3) or stall (code 4) halts the descriptor at once. The count is kept, and status bit 2 (babble) or bit 3 (stall) is set.
- R7: A success (code 0) reloads the count to 3 only when the count is non-zero, the PID is OUT or IN, and the endpoint is high-speed or the descriptor is asynchronous. Otherwise the count is unchanged.
- R8: The token byte is E1h for PID 00 (OUT), 69h for 01 (IN) and 2Dh for 10 (SETUP). The token-valid output is high while the descriptor is active with such a PID.
- R9: PID 11 raises the configuration-error output, sets the token byte to 00h and keeps token-valid low.
- R10: While halted or not active, outcomes change nothing until the next load.
- R11: Loading a count of zero with the high-speed flag low sets the illegal-configuration output until the next load.
- R12: Each halt raises the sticky interrupt request only if the interrupt enable input is high in the halting cycle.
- R13: After reset, the count is zero, every flag, status bit and interrupt output is low, and token-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load a new descriptor setup |
| load_cnt_i | input | 2 | Starting error budget |
| load_pid_i | input | 2 | PID code |
| load_hs_i | input | 1 | Endpoint is high-speed |
| load_async_i | input | 1 | Descriptor is in the asynchronous schedule |
| irq_en_i | input | 1 | Error interrupt enable |
| outcome_vld_i | input | 1 | A transaction outcome is presented |
| outcome_i | input | 3 | Outcome code: 0 ok, 1 transaction error, 2 data buffer error, 3 babble, 4 stall |
| err_cnt_o | output | 2 | Remaining error budget |
| active_o | output | 1 | Descriptor active |
| halted_o | output | 1 | Descriptor halted |
| err_status_o | output | 4 | Sticky causes: [0] transaction, [1] data buffer, [2] babble, [3] stall |
| irq_o | output | 1 | Error interrupt request |
| token_o | output | 8 | Token byte for the PID |
| token_vld_o | output | 1 | Token byte is usable |
| cfg_err_o | output | 1 | Reserved PID loaded |
| illegal_cfg_o | output | 1 | Zero budget loaded with a full- or low-speed endpoint |

## Verification
The count, the flags, the status bits and the interrupt request are all registered, so each shows the effect of a load or an outcome one rising edge after that stimulus. The token byte, token-valid and the configuration-error output are derived combinationally from registered state, so they also settle one edge after the load. The driver applies each stimulus on a falling edge and queues the full expected output bundle for it. The monitor pops that entry one time unit after the next rising edge, which is exactly one register stage later, and compares it away from both edges.

// File: rtl/td_retry_pkg.sv
package td_retry_pkg;
  localparam int PID_W = 2;
  localparam int TOK_W = 8;
  localparam int ST_W  = 4;

  typedef enum logic [2:0] {
    OC_OK     = 3'd0,
    OC_XACT   = 3'd1,
    OC_DBUF   = 3'd2,
    OC_BABBLE = 3'd3,
    OC_STALL  = 3'd4
  } outcome_e;

  localparam logic [PID_W-1:0] PID_OUT   = 2'b00;
  localparam logic [PID_W-1:0] PID_IN    = 2'b01;
  localparam logic [PID_W-1:0] PID_SETUP = 2'b10;
  localparam logic [PID_W-1:0] PID_RSVD  = 2'b11;

  // Status bit positions
  localparam int ST_XACT = 0;
  localparam int ST_DBUF = 1;
  localparam int ST_BAB  = 2;
  localparam int ST_STL  = 3;

  function automatic logic [TOK_W-1:0] pid_to_token(input logic [PID_W-1:0] pid);
    case (pid)
      PID_OUT:   return 8'hE1;
      PID_IN:    return 8'h69;
      PID_SETUP: return 8'h2D;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic pid_is_data(input logic [PID_W-1:0] pid);
    return (pid == PID_OUT) || (pid == PID_IN);
  endfunction
endpackage

// File: rtl/td_token_map.sv
module td_token_map
  import td_retry_pkg::*;
(
  input  logic [PID_W-1:0] pid_i,
  input  logic             active_i,
  output logic [TOK_W-1:0] token_o,
  output logic             token_vld_o,
  output logic             rsvd_o
);
  assign rsvd_o      = (pid_i == PID_RSVD);
  assign token_o     = pid_to_token(pid_i);
  assign token_vld_o = active_i & ~rsvd_o;

  always_comb begin
    if (rsvd_o) assert_rsvd_no_token_R9: assert (token_o == '0 && !token_vld_o);
  end
endmodule

// File: rtl/td_err_counter.sv
module td_err_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             counting;

  assign counting   = (cnt_q != '0);
  assign last_err_o = dec_i & (cnt_q == CNT_ONE);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (dec_i && counting)   cnt_q <= cnt_q - CNT_ONE;
    else if (reload_i && counting) cnt_q <= CNT_MAX;
  end

  assert_dec_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  assert_zero_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/td_retry_ctrl.sv
module td_retry_ctrl
  import td_retry_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic [PID_W-1:0] load_pid_i,
  input  logic             load_hs_i,
  input  logic             load_async_i,
  input  logic             irq_en_i,
  input  logic             outcome_vld_i,
  input  logic [2:0]       outcome_i,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             active_o,
  output logic             halted_o,
  output logic [ST_W-1:0]  err_status_o,
  output logic             irq_o,
  output logic [TOK_W-1:0] token_o,
  output logic             token_vld_o,
  output logic             cfg_err_o,
  output logic             illegal_cfg_o
);
  logic             active_q, halted_q, irq_q, illegal_q, hs_q, async_q;
  logic [PID_W-1:0] pid_q;
  logic [ST_W-1:0]  status_q;
  logic [CNT_W-1:0] cnt;

  // Named internal events
  logic live, take;
  logic evt_ok, evt_xact, evt_dbuf, evt_bab, evt_stl;
  logic evt_reload, evt_last, evt_halt;

  assign live     = active_q & ~halted_q;
  assign take     = outcome_vld_i & live & ~load_i;
  assign evt_ok   = take & (outcome_i == OC_OK);
  assign evt_xact = take & (outcome_i == OC_XACT);
  assign evt_dbuf = take & (outcome_i == OC_DBUF);
  assign evt_bab  = take & (outcome_i == OC_BABBLE);
  assign evt_stl  = take & (outcome_i == OC_STALL);
  assign evt_reload = evt_ok & (hs_q | async_q) & pid_is_data(pid_q);
  assign evt_halt = evt_last | evt_bab | evt_stl;

  td_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .load_val_i (load_cnt_i),
    .dec_i      (evt_xact),
    .reload_i   (evt_reload),
    .cnt_o      (cnt),
    .last_err_o (evt_last)
  );

  td_token_map u_tok (
    .pid_i       (pid_q),
    .active_i    (active_q),
    .token_o     (token_o),
    .token_vld_o (token_vld_o),
    .rsvd_o      (cfg_err_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      halted_q  <= 1'b0;
      irq_q     <= 1'b0;
      illegal_q <= 1'b0;
      hs_q      <= 1'b0;
      async_q   <= 1'b0;
      pid_q     <= PID_OUT;
      status_q  <= '0;
    end else if (load_i) begin
      active_q  <= 1'b1;
      halted_q  <= 1'b0;
      irq_q     <= 1'b0;
      illegal_q <= (load_cnt_i == '0) & ~load_hs_i;
      hs_q      <= load_hs_i;
      async_q   <= load_async_i;
      pid_q     <= load_pid_i;
      status_q  <= '0;
    end else begin
      if (evt_halt) begin
        active_q <= 1'b0;
        halted_q <= 1'b1;
        if (irq_en_i) irq_q <= 1'b1;
      end
      if (evt_last) status_q[ST_XACT] <= 1'b1;
      if (evt_dbuf) status_q[ST_DBUF] <= 1'b1;
      if (evt_bab)  status_q[ST_BAB]  <= 1'b1;
      if (evt_stl)  status_q[ST_STL]  <= 1'b1;
    end
  end

  assign err_cnt_o     = cnt;
  assign active_o      = active_q;
  assign halted_o      = halted_q;
  assign err_status_o  = status_q;
  assign irq_o         = irq_q;
  assign illegal_cfg_o = illegal_q;

  assert_halt_inactive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> !active_q);

  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_halt && !irq_en_i && !irq_q) |=> !irq_q);

  assert_ignore_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !load_i) |=> (halted_q && $stable(status_q) && $stable(cnt)));

  assert_dbuf_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dbuf |=> (cnt == $past(cnt) && !halted_q));

  assert_babstall_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_bab || evt_stl) |=> (halted_q && cnt == $past(cnt)));
endmodule

// File: tb/sim_td_retry_ctrl.sv
`timescale 1ns/100ps
module sim_td_retry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       load_i = 0, load_hs_i = 0, load_async_i = 0, irq_en_i = 0, outcome_vld_i = 0;
  logic [1:0] load_cnt_i = 0, load_pid_i = 0;
  logic [2:0] outcome_i = 0;
  logic [1:0] err_cnt_o;
  logic       active_o, halted_o, irq_o, token_vld_o, cfg_err_o, illegal_cfg_o;
  logic [3:0] err_status_o;
  logic [7:0] token_o;

  td_retry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_cnt_i(load_cnt_i),
    .load_pid_i(load_pid_i), .load_hs_i(load_hs_i), .load_async_i(load_async_i),
    .irq_en_i(irq_en_i), .outcome_vld_i(outcome_vld_i), .outcome_i(outcome_i),
    .err_cnt_o(err_cnt_o), .active_o(active_o), .halted_o(halted_o),
    .err_status_o(err_status_o), .irq_o(irq_o), .token_o(token_o),
    .token_vld_o(token_vld_o), .cfg_err_o(cfg_err_o), .illegal_cfg_o(illegal_cfg_o)
  );

  typedef struct {
    string      tag;
    logic [20:0] exp;
  } item_t;
  item_t q[$];

  int total = 0, bad = 0;
  bit done = 0;

  // Reference state
  logic [1:0] m_cnt = 0, m_pid = 0;
  logic       m_act = 0, m_hlt = 0, m_irq = 0, m_ill = 0, m_hs = 0, m_as = 0;
  logic [3:0] m_st = 0;

  function automatic logic [20:0] pack_exp();
    logic [7:0] tk;
    tk = (m_pid == 2'd0) ? 8'hE1 : (m_pid == 2'd1) ? 8'h69 : (m_pid == 2'd2) ? 8'h2D : 8'h00;
    return {m_cnt, m_act, m_hlt, m_st, m_irq, tk, (m_act && m_pid != 2'd3), (m_pid == 2'd3), m_ill};
  endfunction

  task automatic stop_desc(input int bitpos, input logic ien);
    m_act = 0; m_hlt = 1; m_st[bitpos] = 1'b1;
    if (ien) m_irq = 1;
  endtask

  task automatic step(input logic ld, input logic [1:0] lc, input logic [1:0] lp,
                      input logic lhs, input logic las, input logic ien,
                      input logic ov, input logic [2:0] oc, input string tag);
    item_t it;
    @(negedge clk);
    load_i = ld; load_cnt_i = lc; load_pid_i = lp; load_hs_i = lhs;
    load_async_i = las; irq_en_i = ien; outcome_vld_i = ov; outcome_i = oc;
    if (ld) begin
      m_cnt = lc; m_pid = lp; m_hs = lhs; m_as = las;
      m_act = 1; m_hlt = 0; m_st = 0; m_irq = 0;
      m_ill = (lc == 0) && !lhs;
    end else if (ov && m_act && !m_hlt) begin
      case (oc)
        3'd0: if ((m_hs || m_as) && m_pid < 2 && m_cnt != 0) m_cnt = 2'd3;
        3'd1: if (m_cnt == 1) begin m_cnt = 0; stop_desc(0, ien); end
              else if (m_cnt > 1) m_cnt = m_cnt - 1;
        3'd2: m_st[1] = 1'b1;
        3'd3: stop_desc(2, ien);
        3'd4: stop_desc(3, ien);
        default: ;
      endcase
    end
    it.tag = tag;
    it.exp = pack_exp();
    q.push_back(it);
  endtask

  task automatic outc(input logic [2:0] oc, input logic ien, input string tag);
    step(0, 0, 0, 0, 0, ien, 1, oc, tag);
  endtask

  task automatic load(input logic [1:0] lc, input logic [1:0] lp, input logic lhs,
                      input logic las, input string tag);
    step(1, lc, lp, lhs, las, 0, 0, 0, tag);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [20:0] act;
      it = q.pop_front();
      act = {err_cnt_o, active_o, halted_o, err_status_o, irq_o, token_o,
             token_vld_o, cfg_err_o, illegal_cfg_o};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, 0, "R13 reset state");
    outc(3'd4, 1, "R10 outcome before any load ignored");
    load(2'd3, 2'd1, 1, 0, "R1 load / R8 IN token");
    outc(3'd1, 1, "R2 decrement 3->2");
    outc(3'd0, 1, "R7 hs IN success reloads");
    outc(3'd1, 1, "R2 decrement 3->2 again");
    outc(3'd1, 1, "R2 decrement 2->1");
    outc(3'd2, 1, "R5 data buffer error keeps count");
    outc(3'd1, 1, "R3 1->0 halts with irq");
    outc(3'd0, 1, "R10 success ignored while halted");
    outc(3'd4, 1, "R10 stall ignored while halted");
    load(2'd2, 2'd0, 0, 0, "R8 OUT token full-speed load");
    outc(3'd1, 1, "R2 decrement 2->1");
    outc(3'd0, 1, "R7 no reload for full-speed periodic");
    step(1, 2'd1, 2'd2, 1, 1, 1, 1, 3'd4, "R1 load wins over same-cycle stall");
    outc(3'd0, 0, "R7 no reload for SETUP");
    outc(3'd3, 0, "R6 babble halts / R12 no irq when disabled");
    load(2'd0, 2'd0, 0, 0, "R11 zero count full-speed illegal");
    outc(3'd1, 1, "R4 unlimited retries");
    outc(3'd1, 1, "R4 unlimited retries again");
    outc(3'd0, 1, "R4 zero count not reloaded");
    outc(3'd4, 1, "R6 stall halts with irq / R12");
    load(2'd0, 2'd1, 1, 0, "R11 zero count high-speed legal");
    outc(3'd0, 1, "R4 hs zero count no reload");
    load(2'd2, 2'd3, 1, 1, "R9 reserved PID");
    outc(3'd3, 1, "R6 babble keeps count 2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule